// File: doc/BRIEF.md
# Serial Word Receiver with Idle-Gap End Detection

This block takes a self-clocked serial word arriving on a two-wire line pair whose timing is unrelated to the system clock. A bit is present while exactly one of the two wires is asserted. The block brings both wires into the system clock domain and recovers a bit clock from them. Every recovered bit is written into a 32-bit word register, and the block counts the bits as they arrive. There is no fixed frame length. The message ends once the line has stayed quiet for a programmable number of protocol reference ticks after the last bit.

When that quiet period runs out, the block emits a single-cycle message pulse. The pulse carries the collected word and the number of bits received. The internal state then clears so the next message starts fresh. A loop-back select replaces the external wire pair with a local transmit pair so that a transmitter can be tested without external wiring. Reception behaves the same on either source.

Top module: `serial_gap_rx`

## Requirements
- R1: After synchronous reset, `msg_valid` is 0, `msg_word` is 0 and `msg_bits` is 0.
- R2: A bit is received when exactly one wire is asserted. The high wire alone means 1 and the low wire alone means 0. The first bit of a message is stored at `msg_word` bit 0, and bit k is stored at bit k.
- R3: A pulse during which both wires are asserted is not a bit. The bit count and the stored word are unchanged by it.
- R4: The idle counter advances only on cycles where `ref_tick` is 1. With `ref_tick` held at 1, `msg_valid` rises on the (G+4)-th rising clock edge after the line inputs go idle, where G is the programmed gap.
- R5: Each falling edge of the recovered bit clock clears the idle counter. A message whose gaps between bits are shorter than G stays open until its final gap expires.
- R6: `msg_valid` lasts exactly one clock cycle. The next message starts with a zero word and a zero count.
- R7: `msg_bits` counts received bits and holds at 63. Bits beyond the 32nd are not stored in `msg_word`.
- R8: A programmed gap of 0 disables end-of-message detection.
- R9: When `loop_en` is 1, the receiver takes `loop_hi`/`loop_lo` and ignores `line_hi`/`line_lo`, and it decodes them the same way.
- R10: A cycle with `gap_we` high loads `gap_val` into the gap register, and the new value takes effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable for each protocol reference clock period |
| line_hi | input | 1 | External wire, asserted for a 1 bit |
| line_lo | input | 1 | External wire, asserted for a 0 bit |
| loop_hi | input | 1 | Local transmit wire, asserted for a 1 bit |
| loop_lo | input | 1 | Local transmit wire, asserted for a 0 bit |
| loop_en | input | 1 | Selects the local transmit pair as the receiver source |
| gap_we | input | 1 | Gap register write strobe |
| gap_val | input | 8 | New gap value in reference ticks |
| msg_valid | output | 1 | One-cycle end-of-message pulse |
| msg_word | output | 32 | Received bits, first bit at bit 0 |
| msg_bits | output | 6 | Received bit count, saturating at 63 |

## Verification
A wrong idle count shows up at the ports as a pulse that arrives early, arrives late or never arrives. The bench measures that latency to the exact edge, both with the reference tick held and with it stalled. A bit register or bit counter that is not cleared corrupts the very next message. For that reason a one-bit message follows an all-ones message in the vector table. A wrong source select or a wrong decode appears in the next delivered word as a flipped or missing bit. Saturation faults appear only after 63 bits, so a 70-bit message is sent on purpose.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
    parameter int WORD_W = 32;
    parameter int CNT_W  = 6;
    parameter int GAP_W  = 8;

    typedef struct packed {
        logic rise;
        logic fall;
        logic bit_ok;
        logic bit_val;
    } sgr_event_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  bits;
    } sgr_msg_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/sgr_line_front.sv
module sgr_line_front
    import sgr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_hi,
    input  logic       line_lo,
    input  logic       loop_hi,
    input  logic       loop_lo,
    input  logic       loop_en,
    output sgr_event_t ev
);
    logic sel_hi, sel_lo;
    logic [SYNC_STAGES-1:0] hi_sr, lo_sr;
    logic s_hi, s_lo, rclk, rclk_q;

    assign sel_hi = loop_en ? loop_hi : line_hi;
    assign sel_lo = loop_en ? loop_lo : line_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_sr  <= '0;
            lo_sr  <= '0;
            rclk_q <= 1'b0;
        end else begin
            hi_sr  <= {hi_sr[SYNC_STAGES-2:0], sel_hi};
            lo_sr  <= {lo_sr[SYNC_STAGES-2:0], sel_lo};
            rclk_q <= rclk;
        end
    end

    assign s_hi = hi_sr[SYNC_STAGES-1];
    assign s_lo = lo_sr[SYNC_STAGES-1];
    assign rclk = s_hi | s_lo;

    always_comb begin
        ev.rise    = rclk & ~rclk_q;
        ev.fall    = ~rclk & rclk_q;
        ev.bit_ok  = ev.rise & (s_hi ^ s_lo);
        ev.bit_val = s_hi;
    end
endmodule

// File: rtl/sgr_shifter.sv
module sgr_shifter
    import sgr_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  sgr_event_t    ev,
    output logic [W-1:0]  word,
    output logic [CW-1:0] bits
);
    localparam int IDX_W = $clog2(W);
    localparam logic [CW-1:0] MAXC = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
            bits <= '0;
        end else if (ev.bit_ok) begin
            if (bits < CW'(W))
                word[bits[IDX_W-1:0]] <= ev.bit_val;
            bits <= sat_inc(bits);
        end
    end

    // R7: the count stays at its maximum until cleared
    a_r7_count_holds: assert property (@(posedge clk) disable iff (rst)
        (bits == MAXC && !clear) |=> bits == MAXC);
    // R3: a pulse with both wires asserted leaves the count alone
    a_r3_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !ev.bit_ok && !clear) |=> $stable(bits));
endmodule

// File: rtl/sgr_gap_timer.sv
module sgr_gap_timer
    import sgr_pkg::*;
#(
    parameter int GW = GAP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_tick,
    input  logic          fall,
    input  logic          armed,
    input  logic [GW-1:0] gap,
    output logic          hit
);
    logic [GW-1:0] cnt;
    logic          enabled;

    assign enabled = armed && (gap != '0);
    assign hit     = enabled && (cnt == gap);

    always_ff @(posedge clk) begin
        if (rst || fall || hit)
            cnt <= '0;
        else if (ref_tick && enabled)
            cnt <= cnt + 1'b1;
    end

    // R5: a falling edge of the recovered clock clears the counter
    a_r5_clear_on_fall: assert property (@(posedge clk) disable iff (rst)
        fall |=> cnt == '0);
    // R4: without a reference tick the counter only holds or clears
    a_r4_tick_only: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick && !fall && !hit) |=> $stable(cnt));
endmodule

// File: rtl/serial_gap_rx.sv
module serial_gap_rx
    import sgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              line_hi,
    input  logic              line_lo,
    input  logic              loop_hi,
    input  logic              loop_lo,
    input  logic              loop_en,
    input  logic              gap_we,
    input  logic [GAP_W-1:0]  gap_val,
    output logic              msg_valid,
    output logic [WORD_W-1:0] msg_word,
    output logic [CNT_W-1:0]  msg_bits
);
    sgr_event_t        ev;
    sgr_msg_t          cur;
    logic [GAP_W-1:0]  gap_q;
    logic              hit;

    sgr_line_front #(.SYNC_STAGES(2)) u_front (
        .clk(clk), .rst(rst),
        .line_hi(line_hi), .line_lo(line_lo),
        .loop_hi(loop_hi), .loop_lo(loop_lo),
        .loop_en(loop_en), .ev(ev)
    );

    sgr_shifter #(.W(WORD_W), .CW(CNT_W)) u_shift (
        .clk(clk), .rst(rst), .clear(hit), .ev(ev),
        .word(cur.word), .bits(cur.bits)
    );

    sgr_gap_timer #(.GW(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fall(ev.fall),
        .armed(cur.bits != '0), .gap(gap_q), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= '0;
            msg_valid <= 1'b0;
            msg_word  <= '0;
            msg_bits  <= '0;
        end else begin
            if (gap_we)
                gap_q <= gap_val;
            msg_valid <= hit;
            if (hit) begin
                msg_word <= cur.word;
                msg_bits <= cur.bits;
            end
        end
    end

    // R6: single-cycle pulse, and the collected state is already cleared
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);
    a_r6_fresh_start: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> cur.bits == '0);
    // R8: a zero gap produces no message
    a_r8_zero_gap: assert property (@(posedge clk) disable iff (rst)
        (gap_q == '0) |=> !msg_valid);
endmodule

// File: tb/test_serial_gap_rx.sv
module test_serial_gap_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b1;
    logic line_hi = 1'b0, line_lo = 1'b0, loop_hi = 1'b0, loop_lo = 1'b0;
    logic loop_en = 1'b0, gap_we = 1'b0;
    logic [7:0] gap_val = 8'd0;
    logic msg_valid;
    logic [31:0] msg_word;
    logic [5:0] msg_bits;

    int checks = 0, fails = 0, pulses = 0;

    always #2 clk = ~clk;

    serial_gap_rx i_serial_gap_rx (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .line_hi(line_hi), .line_lo(line_lo),
        .loop_hi(loop_hi), .loop_lo(loop_lo), .loop_en(loop_en),
        .gap_we(gap_we), .gap_val(gap_val),
        .msg_valid(msg_valid), .msg_word(msg_word), .msg_bits(msg_bits)
    );

    always @(negedge clk) if (!rst && msg_valid) pulses++;

    typedef struct packed {
        logic [31:0] pat;
        logic [6:0]  n;
        logic [7:0]  gap;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'hA5C3_0F96, 7'd32, 8'd20},
        '{32'hFFFF_FFFF, 7'd32, 8'd12},
        '{32'h0000_0001, 7'd1,  8'd16},
        '{32'h0000_2B6D, 7'd14, 8'd30}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic h, input logic l, input logic other_noise);
        if (loop_en) begin
            loop_hi = h; loop_lo = l; line_hi = other_noise; line_lo = 1'b0;
        end else begin
            line_hi = h; line_lo = l; loop_hi = 1'b0; loop_lo = 1'b0;
        end
    endtask

    task automatic set_gap(input logic [7:0] g);
        @(negedge clk); gap_we = 1'b1; gap_val = g;
        @(negedge clk); gap_we = 1'b0;
    endtask

    // Sends n bits; the last bit's idle is driven and the task returns at once.
    task automatic send(input logic [31:0] pat, input int n, input int idle,
                        input int both_at, input logic noise);
        for (int i = 0; i < n; i++) begin
            if (i == both_at) begin
                @(negedge clk); drive(1'b1, 1'b1, noise);
                repeat (4) @(negedge clk); drive(1'b0, 1'b0, noise);
                repeat (idle - 1) @(negedge clk);
            end
            @(negedge clk); drive(pat[i % 32], ~pat[i % 32], noise);
            repeat (4) @(negedge clk); drive(1'b0, 1'b0, noise);
            if (i != n - 1) repeat (idle - 1) @(negedge clk);
        end
    endtask

    task automatic wait_msg(output int lat, output logic [31:0] w, output logic [5:0] b);
        lat = -1; w = '0; b = '0;
        for (int k = 1; k <= 600; k++) begin
            @(negedge clk);
            if (msg_valid) begin
                lat = k; w = msg_word; b = msg_bits;
                @(negedge clk);
                chk("R6 pulse width", 64'(msg_valid), 64'd0);
                break;
            end
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] pat, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n && i < 32; i++) r[i] = pat[i % 32];
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int lat, p0;
        logic [31:0] w;
        logic [5:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", 64'(msg_valid), 0);
        chk("R1 word", 64'(msg_word), 0);
        chk("R1 bits", 64'(msg_bits), 0);

        // Vector table: R2 decode, R4 latency, R6 fresh start, R10 gap load
        foreach (VECS[v]) begin
            set_gap(VECS[v].gap);
            send(VECS[v].pat, int'(VECS[v].n), 4, -1, 1'b0);
            wait_msg(lat, w, b);
            chk("R2 word", 64'(w), 64'(exp_word(VECS[v].pat, int'(VECS[v].n))));
            chk("R6 bits", 64'(b), 64'(VECS[v].n));
            chk("R4 latency", 64'(lat), 64'(int'(VECS[v].gap) + 4));
            repeat (5) @(negedge clk);
        end

        // R3: a both-asserted pulse inside a message
        set_gap(8'd20);
        send(32'h0000_002D, 6, 4, 2, 1'b0);
        wait_msg(lat, w, b);
        chk("R3 bits", 64'(b), 64'd6);
        chk("R3 word", 64'(w), 64'h2D);

        // R5: inter-bit gaps of 18 cycles stay under a gap of 20
        send(32'h0000_0356, 10, 14, -1, 1'b0);
        wait_msg(lat, w, b);
        chk("R5 bits", 64'(b), 64'd10);
        chk("R5 word", 64'(w), 64'h356);
        chk("R5 latency", 64'(lat), 64'd24);

        // R7: longer than the word, and past saturation
        send(32'h9E37_79B9, 40, 4, -1, 1'b0);
        wait_msg(lat, w, b);
        chk("R7 bits 40", 64'(b), 64'd40);
        chk("R7 word 40", 64'(w), 64'h9E37_79B9);
        send(32'h1234_5678, 70, 4, -1, 1'b0);
        wait_msg(lat, w, b);
        chk("R7 bits sat", 64'(b), 64'd63);
        chk("R7 word sat", 64'(w), 64'h1234_5678);

        // R4: stalled reference tick delays the end
        send(32'h0000_0005, 3, 4, -1, 1'b0);
        ref_tick = 1'b0;
        p0 = pulses;
        repeat (60) @(negedge clk);
        chk("R4 stalled no msg", 64'(pulses - p0), 0);
        ref_tick = 1'b1;
        wait_msg(lat, w, b);
        chk("R4 resume latency", 64'(lat), 64'd21);
        chk("R4 word", 64'(w), 64'h5);

        // R8 and R10: zero gap disables; a later write ends the message
        set_gap(8'd0);
        p0 = pulses;
        send(32'h0000_0013, 5, 4, -1, 1'b0);
        repeat (100) @(negedge clk);
        chk("R8 no msg", 64'(pulses - p0), 0);
        gap_we = 1'b1; gap_val = 8'd10;
        @(negedge clk); gap_we = 1'b0;
        wait_msg(lat, w, b);
        chk("R10 latency", 64'(lat + 1), 64'd12);
        chk("R8 bits kept", 64'(b), 64'd5);
        chk("R8 word kept", 64'(w), 64'h13);

        // R9: loop-back source with noise on the external pair
        set_gap(8'd20);
        loop_en = 1'b1;
        send(32'h0000_6C3A, 15, 4, -1, 1'b1);
        wait_msg(lat, w, b);
        chk("R9 word", 64'(w), 64'h6C3A);
        chk("R9 bits", 64'(b), 64'd15);
        chk("R9 latency", 64'(lat), 64'd24);
        drive(1'b0, 1'b0, 1'b0);
        loop_en = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 no stray msg", 64'(msg_valid), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule